// File: doc/BRIEF.md
# Serial In-System Programming Command Slave

This block is the target-side serial port used to program on-chip non-volatile memories while the device is held in reset by an external programmer. The programmer supplies a serial clock and a data input line. Both are oversampled by the system clock through a synchronizer, and the block drives a data output line back. Every instruction is a 32-bit frame made of four bytes. The block collects each frame, decodes it into a memory request for a back end, and shifts response data out while the frame is still being received.

The block ignores every command until a valid enable frame has been received. It returns the previously received byte on the output line, so a programmer can confirm that it is in step by watching the echo of the enable frame's second byte. Read commands raise their request after the third byte, so the read data is ready in time for the fourth byte. Write, load and erase commands raise their request after the fourth byte. A busy poll is answered locally from the back end's busy input and raises no request.

Other recognised opcodes map to the following request codes. First byte 0x4C is a program page commit (op 2, address {byte2[1:0], byte3[7:4]}). 0xA0 is an EEPROM read (op 3). 0x50 or 0x58 with second byte 0x00 or 0x08 is a fuse read (op 7). 0xAC with second byte 111xxxxx is a lock write (op 8). 0x58 0x00 is a lock read (op 9).

Top module: `isp_cmd_slave`

## Requirements
- R1: The data input line is captured at each synchronised rising edge of the serial clock, MSB first. After 32 captured bits the bit counter wraps, so the next bit starts a new frame.
- R2: The output line changes only after a synchronised falling edge of the serial clock. Each response byte is sent MSB first. The response during the first byte of every frame is 0x00.
- R3: During byte 2 of a frame the output carries the received byte 1. During byte 3 it carries the received byte 2. During byte 4 it carries the received byte 3, unless rule R6 or R7 applies.
- R4: The frame 0xAC, 0x53, any, any enables the block at the end of its fourth byte. Before that, no request is raised for any frame.
- R5: While isp_sel_i is low, the bit counter, the enabled state and the frame buffer are cleared, the output line is 0, and any pending request is dropped.
- R6: When enabled, a frame whose first byte is 0xF0 returns {7'b0, busy_i} as its fourth output byte and raises no request. busy_i is taken at the falling edge that starts byte 4.
- R7: When enabled, first byte 0x20 or 0x28 raises request op 0 after byte 3. hi equals first-byte bit 3, the address is {byte2[1:0], byte3}, and the fourth output byte is the read data returned for that request.
- R8: When enabled, first byte 0x40 or 0x48 raises op 1 after byte 4, with hi equal to bit 3, address byte3[3:0] and write data byte 4. First byte 0xC0 raises op 4, with address byte3[6:0] and write data byte 4.
- R9: When enabled, first byte 0xAC with a second byte of the form 100xxxxx raises op 5 (erase). Second byte 0xA0, 0xA8 or 0xA4 raises op 6 (fuse write), with address 0, 1 or 2 respectively and write data byte 4.
- R10: A frame with an unrecognised first byte raises no request, and its fourth output byte is the echo of byte 3.
- R11: req_o stays high, with its op, hi, address and write data unchanged, until ack_i is seen. For a read, rdata_i is captured in the cycle ack_i is high.
- R12: When enabled, first byte 0x30 raises op 10 (signature read) after byte 3, with address byte3[1:0], and returns the read data in byte 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| isp_sel_i | input | 1 | High while the device is held in programming reset |
| sck_i | input | 1 | Serial clock from the programmer (asynchronous) |
| mosi_i | input | 1 | Serial data in (asynchronous) |
| miso_o | output | 1 | Serial data out |
| req_o | output | 1 | Memory request, held until acknowledged |
| req_op_o | output | 4 | Request code |
| req_hi_o | output | 1 | High/low byte select of a program word |
| req_addr_o | output | 10 | Request address |
| req_wdata_o | output | 8 | Write data |
| ack_i | input | 1 | Back-end acknowledge |
| rdata_i | input | 8 | Read data, valid with ack_i |
| busy_i | input | 1 | Back end still programming |

## Verification
A slipped bit counter or frame buffer shows up within one frame. The echo bytes come out shifted, and requests carry wrong addresses or codes. A stale enabled state shows up at the next frame, either as a request raised before enabling or as none raised after it. A request register that drops early or changes its fields is seen in the same cycle at the request port. A wrong capture of read data shows up as a wrong fourth byte in the same frame.

// File: rtl/isp_pkg.sv
// Shared types and the command decoder of the serial programming slave.
// Assumes frames of four 8-bit bytes, first byte most significant.
package isp_pkg;

    localparam int ISP_BYTE_W = 8;
    localparam int ISP_ADDR_W = 10;

    typedef enum logic [3:0] {
        OP_RD_PROG  = 4'd0,
        OP_LD_PROG  = 4'd1,
        OP_WR_PAGE  = 4'd2,
        OP_RD_EE    = 4'd3,
        OP_WR_EE    = 4'd4,
        OP_ERASE    = 4'd5,
        OP_WR_FUSE  = 4'd6,
        OP_RD_FUSE  = 4'd7,
        OP_WR_LOCK  = 4'd8,
        OP_RD_LOCK  = 4'd9,
        OP_RD_SIG   = 4'd10
    } isp_op_e;

    typedef struct packed {
        logic                  valid;
        logic                  is_read;
        logic                  is_poll;
        logic                  is_enable;
        isp_op_e               op;
        logic                  hi;
        logic [ISP_ADDR_W-1:0] addr;
        logic [ISP_BYTE_W-1:0] wdata;
    } isp_cmd_t;

    // Map four frame bytes onto a request description.
    function automatic isp_cmd_t isp_decode(input logic [7:0] b1, input logic [7:0] b2,
                                            input logic [7:0] b3, input logic [7:0] b4);
        isp_cmd_t c;
        c       = '0;
        c.wdata = b4;
        case (b1)
            8'h20, 8'h28: begin
                c.valid = 1'b1; c.is_read = 1'b1; c.op = OP_RD_PROG;
                c.hi = b1[3]; c.addr = {b2[1:0], b3};
            end
            8'h40, 8'h48: begin
                c.valid = 1'b1; c.op = OP_LD_PROG; c.hi = b1[3];
                c.addr = ISP_ADDR_W'(b3[3:0]);
            end
            8'h4C: begin
                c.valid = 1'b1; c.op = OP_WR_PAGE;
                c.addr = ISP_ADDR_W'({b2[1:0], b3[7:4]});
            end
            8'hA0: begin
                c.valid = 1'b1; c.is_read = 1'b1; c.op = OP_RD_EE;
                c.addr = ISP_ADDR_W'(b3[6:0]);
            end
            8'hC0: begin
                c.valid = 1'b1; c.op = OP_WR_EE; c.addr = ISP_ADDR_W'(b3[6:0]);
            end
            8'hAC: begin
                if (b2 == 8'h53) begin
                    c.is_enable = 1'b1;
                end else if (b2[7:5] == 3'b100) begin
                    c.valid = 1'b1; c.op = OP_ERASE;
                end else if (b2[7:5] == 3'b111) begin
                    c.valid = 1'b1; c.op = OP_WR_LOCK;
                end else if (b2 == 8'hA0) begin
                    c.valid = 1'b1; c.op = OP_WR_FUSE; c.addr = ISP_ADDR_W'(0);
                end else if (b2 == 8'hA8) begin
                    c.valid = 1'b1; c.op = OP_WR_FUSE; c.addr = ISP_ADDR_W'(1);
                end else if (b2 == 8'hA4) begin
                    c.valid = 1'b1; c.op = OP_WR_FUSE; c.addr = ISP_ADDR_W'(2);
                end
            end
            8'h50: begin
                if (b2 == 8'h00 || b2 == 8'h08) begin
                    c.valid = 1'b1; c.is_read = 1'b1; c.op = OP_RD_FUSE;
                    c.addr = (b2 == 8'h08) ? ISP_ADDR_W'(2) : ISP_ADDR_W'(0);
                end
            end
            8'h58: begin
                if (b2 == 8'h00) begin
                    c.valid = 1'b1; c.is_read = 1'b1; c.op = OP_RD_LOCK;
                end else if (b2 == 8'h08) begin
                    c.valid = 1'b1; c.is_read = 1'b1; c.op = OP_RD_FUSE;
                    c.addr = ISP_ADDR_W'(1);
                end
            end
            8'h30: begin
                c.valid = 1'b1; c.is_read = 1'b1; c.op = OP_RD_SIG;
                c.addr = ISP_ADDR_W'(b3[1:0]);
            end
            8'hF0: c.is_poll = 1'b1;
            default: c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/isp_edge_sync.sv
// Brings the asynchronous serial clock and data into the system clock domain
// and flags rising and falling serial-clock edges with one-cycle pulses.
// Assumes each serial-clock phase lasts at least two system clocks.
module isp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic mosi_i,
    output logic rise_o,
    output logic fall_o,
    output logic mosi_o
);
    logic [STAGES-1:0] sck_sh;
    logic [STAGES-1:0] mosi_sh;
    logic              sck_d;

    // Synchronizer chains plus one delayed copy of the clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sh  <= '0;
            mosi_sh <= '0;
            sck_d   <= 1'b0;
        end else begin
            sck_sh  <= {sck_sh[STAGES-2:0], sck_i};
            mosi_sh <= {mosi_sh[STAGES-2:0], mosi_i};
            sck_d   <= sck_sh[STAGES-1];
        end
    end

    assign rise_o = sck_sh[STAGES-1] & ~sck_d;
    assign fall_o = ~sck_sh[STAGES-1] & sck_d;
    assign mosi_o = mosi_sh[STAGES-1];

endmodule

// File: rtl/isp_frame_rx.sv
// Counts serial bits and shifts them into the frame buffer, MSB first.
// Pulses stb_o in the cycle the new count and buffer are visible.
// Assumes clr_i is held while the port is deselected.
module isp_frame_rx #(
    parameter int FRAME_BITS = 32,
    localparam int CW = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  rise_i,
    input  logic                  mosi_i,
    output logic [CW-1:0]         cnt_o,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  stb_o
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    // Bit counter, frame shift register and the strobe that follows each capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o   <= '0;
            frame_o <= '0;
            stb_o   <= 1'b0;
        end else begin
            stb_o <= rise_i;
            if (rise_i) begin
                frame_o <= {frame_o[FRAME_BITS-2:0], mosi_i};
                cnt_o   <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
            end
        end
    end

    // R1: a strobe always follows a captured rising edge.
    p_stb_after_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(rise_i));

endmodule

// File: rtl/isp_resp_tx.sv
// Output shifter: on a serial-clock falling edge it either loads a new byte
// (at a byte boundary) or shifts the current byte left by one.
// Assumes the loaded byte is presented by the caller in the same cycle.
module isp_resp_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              miso_o
);
    logic [BYTE_W-1:0] sh;

    // Load or shift the response byte at each falling serial-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh <= '0;
        end else if (fall_i) begin
            sh <= load_i ? byte_i : {sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso_o = sh[BYTE_W-1];

    // R2: the output line only moves after a falling edge.
    p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_i && !clr_i) |=> $stable(miso_o));

endmodule

// File: rtl/isp_cmd_slave.sv
// Top of the serial programming command slave: synchronises the serial port,
// collects 32-bit frames, gates commands on the enable frame, issues memory
// requests held until acknowledged, and selects each response byte.
// Assumes isp_sel_i is synchronous to clk and the back end acknowledges a
// read before the following serial-clock falling edge.
module isp_cmd_slave
    import isp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = ISP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              isp_sel_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              req_o,
    output logic [3:0]        req_op_o,
    output logic              req_hi_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [7:0]        req_wdata_o,
    input  logic              ack_i,
    input  logic [7:0]        rdata_i,
    input  logic              busy_i
);
    localparam int BW         = ISP_BYTE_W;
    localparam int FRAME_BITS = 4 * BW;
    localparam int CW         = $clog2(FRAME_BITS);
    localparam int BIW        = $clog2(BW);
    localparam logic [CW-1:0] POS_B3 = CW'(3 * BW);

    logic            clr;
    logic            rise, fall, mosi_s;
    logic [CW-1:0]   cnt;
    logic [FRAME_BITS-1:0] frame;
    logic            stb;
    logic            enabled_q;
    isp_cmd_t        cmd3, cmd4;
    logic            issue;
    isp_cmd_t        issue_cmd;
    logic            req_q, rd_q;
    logic [BW-1:0]   rdat_q;
    isp_op_e         op_q;
    logic            hi_q;
    logic [ISP_ADDR_W-1:0] addr_q;
    logic [BW-1:0]   wdata_q;
    logic            boundary;
    logic [BW-1:0]   load_byte;

    assign clr = ~isp_sel_i;

    isp_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .mosi_i(mosi_i),
        .rise_o(rise), .fall_o(fall), .mosi_o(mosi_s)
    );

    isp_frame_rx #(.FRAME_BITS(FRAME_BITS)) rx_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .rise_i(rise), .mosi_i(mosi_s),
        .cnt_o(cnt), .frame_o(frame), .stb_o(stb)
    );

    // Decode views: after three bytes (reads) and after a full frame (writes).
    always_comb begin
        cmd3 = isp_decode(frame[23:16], frame[15:8], frame[7:0], 8'h00);
        cmd4 = isp_decode(frame[31:24], frame[23:16], frame[15:8], frame[7:0]);
    end

    // Pick the command that launches a request in this cycle, if any.
    always_comb begin
        issue     = 1'b0;
        issue_cmd = cmd4;
        if (stb && enabled_q && !req_q) begin
            if (cnt == POS_B3 && cmd3.valid && cmd3.is_read) begin
                issue     = 1'b1;
                issue_cmd = cmd3;
            end else if (cnt == '0 && cmd4.valid && !cmd4.is_read) begin
                issue = 1'b1;
            end
        end
    end

    // Enabled flag: set by a complete enable frame, cleared on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            enabled_q <= 1'b0;
        end else if (stb && cnt == '0 && cmd4.is_enable) begin
            enabled_q <= 1'b1;
        end
    end

    // Request register: launch, hold until acknowledge, capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            req_q   <= 1'b0;
            rd_q    <= 1'b0;
            op_q    <= OP_RD_PROG;
            hi_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdat_q  <= '0;
        end else if (issue) begin
            req_q   <= 1'b1;
            rd_q    <= issue_cmd.is_read;
            op_q    <= issue_cmd.op;
            hi_q    <= issue_cmd.hi;
            addr_q  <= issue_cmd.addr;
            wdata_q <= issue_cmd.wdata;
        end else if (req_q && ack_i) begin
            req_q <= 1'b0;
            if (rd_q) rdat_q <= rdata_i;
        end
    end

    // Response byte chosen at each byte boundary.
    always_comb begin
        boundary = (cnt[BIW-1:0] == '0);
        case (cnt[CW-1:BIW])
            2'd0:    load_byte = '0;
            2'd3: begin
                if (enabled_q && cmd3.is_poll)
                    load_byte = {{(BW-1){1'b0}}, busy_i};
                else if (enabled_q && cmd3.valid && cmd3.is_read)
                    load_byte = rdat_q;
                else
                    load_byte = frame[BW-1:0];
            end
            default: load_byte = frame[BW-1:0];
        endcase
    end

    isp_resp_tx #(.BYTE_W(BW)) tx_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .fall_i(fall),
        .load_i(boundary), .byte_i(load_byte), .miso_o(miso_o)
    );

    assign req_o       = req_q;
    assign req_op_o    = op_q;
    assign req_hi_o    = hi_q;
    assign req_addr_o  = addr_q[ADDR_W-1:0];
    assign req_wdata_o = wdata_q;

    // R11: a pending request keeps its fields until acknowledged.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && isp_sel_i) |=> (req_o && $stable(req_addr_o)
                                            && $stable(req_op_o) && $stable(req_wdata_o)));

    // R5: deselect silences the request port and the output line.
    p_deselect_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !isp_sel_i |=> (!req_o && !miso_o));

    // R4: while not enabled, no request can start.
    p_no_req_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled_q && !req_o) |=> !req_o);

endmodule

// File: tb/isp_cmd_slave_tb.sv
`timescale 1ns/1ps
module isp_cmd_slave_tb_top;
    localparam int HALF = 10;   // system clocks per serial-clock phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       isp_sel = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       req;
    logic [3:0] req_op;
    logic       req_hi;
    logic [9:0] req_addr;
    logic [7:0] req_wdata;
    logic       ack = 1'b0;
    logic [7:0] rdata;
    logic       busy = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    logic [22:0] reqlog[$];

    always #2 clk = ~clk;

    isp_cmd_slave dut_i (
        .clk(clk), .rst_n(rst_n), .isp_sel_i(isp_sel), .sck_i(sck), .mosi_i(mosi),
        .miso_o(miso), .req_o(req), .req_op_o(req_op), .req_hi_o(req_hi),
        .req_addr_o(req_addr), .req_wdata_o(req_wdata), .ack_i(ack),
        .rdata_i(rdata), .busy_i(busy)
    );

    // Back-end model: read data is a fixed function of the address.
    assign rdata = req_addr[7:0] ^ 8'h5A;

    initial begin
        forever begin
            @(posedge clk);
            if (req && !ack) begin
                ack <= 1'b1;
                reqlog.push_back({req_op, req_hi, req_addr, req_wdata});
            end else begin
                ack <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one frame and collect the 32 output bits sampled before each rise.
    task automatic frame(input logic [31:0] tx, output logic [31:0] rx);
        rx = '0;
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk);
            mosi = tx[i];
            idle(HALF);
            rx = {rx[30:0], miso};
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
        idle(2 * HALF);
    endtask

    task automatic exp_none(input string tag);
        chk(reqlog.size() == 0, tag, reqlog.size(), 0);
        reqlog.delete();
    endtask

    task automatic exp_req(input string tag, input int op, input int hi,
                           input int addr, input int wd);
        logic [22:0] e;
        e = {op[3:0], hi[0], addr[9:0], wd[7:0]};
        chk(reqlog.size() == 1, tag, reqlog.size(), 1);
        if (reqlog.size() >= 1) chk(reqlog[0] == e, tag, reqlog[0], e);
        reqlog.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        idle(5);
        chk(miso == 1'b0, "R5 reset miso", miso, 0);
        chk(req == 1'b0, "R5 reset req", req, 0);
        rst_n = 1'b1;
        idle(3);
        isp_sel = 1'b1;
        idle(3);

        // R4: a read before enabling raises nothing; bytes echo (R2, R3).
        frame(32'h28034500, r);
        exp_none("R4 no request before enable");
        chk(r == 32'h00280345, "R3 echo before enable", r, 32'h00280345);

        // Enable frame; second byte echoed during third.
        frame(32'hAC531122, r);
        chk(r[15:8] == 8'h53, "R3 enable echo", r[15:8], 8'h53);
        chk(r[31:24] == 8'h00, "R2 first byte zero", r[31:24], 0);
        exp_none("R4 enable raises no request");

        // R7 read program high byte.
        frame(32'h28034500, r);
        exp_req("R7 read program request", 0, 1, 10'h345, 0);
        chk(r[7:0] == 8'h1F, "R7 read data byte", r[7:0], 8'h1F);
        chk(r[23:8] == 16'h2803, "R11 read frame echo", r[23:8], 16'h2803);

        // R8 loads and writes; a correct address also proves framing (R1).
        frame(32'h40000799, r);
        exp_req("R1 R8 load program page", 1, 0, 7, 8'h99);
        frame(32'h48000566, r);
        exp_req("R8 load program high", 1, 1, 5, 8'h66);
        frame(32'hC0001234, r);
        exp_req("R8 write eeprom", 4, 0, 8'h12, 8'h34);
        chk(r[7:0] == 8'h12, "R3 write byte4 echo", r[7:0], 8'h12);

        // R9 erase and fuse writes.
        frame(32'hAC9F0000, r);
        exp_req("R9 erase", 5, 0, 0, 0);
        frame(32'hACA800E5, r);
        exp_req("R9 fuse high", 6, 0, 1, 8'hE5);
        frame(32'hACA40001, r);
        exp_req("R9 fuse extended", 6, 0, 2, 8'h01);

        // R6 busy poll.
        busy = 1'b1;
        frame(32'hF0000000, r);
        chk(r[7:0] == 8'h01, "R6 poll busy", r[7:0], 1);
        exp_none("R6 poll no request");
        busy = 1'b0;
        frame(32'hF0000000, r);
        chk(r[7:0] == 8'h00, "R6 poll idle", r[7:0], 0);

        // R10 unknown opcode.
        frame(32'h77123456, r);
        exp_none("R10 unknown opcode");
        chk(r[7:0] == 8'h34, "R10 byte4 echo", r[7:0], 8'h34);

        // R12 signature read.
        frame(32'h30000200, r);
        exp_req("R12 signature request", 10, 0, 2, 0);
        chk(r[7:0] == 8'h58, "R12 signature data", r[7:0], 8'h58);

        // R5 deselect clears the enabled state.
        isp_sel = 1'b0;
        idle(4);
        chk(miso == 1'b0, "R5 deselect miso", miso, 0);
        isp_sel = 1'b1;
        idle(4);
        frame(32'h28034500, r);
        exp_none("R5 disabled after deselect");
        chk(r[7:0] == 8'h45, "R5 byte4 echo after deselect", r[7:0], 8'h45);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule